// File: doc/BRIEF.md
# Quad DAC Double-Buffered Command Executor

This block carries out already-decoded command frames for a four-channel digital-to-analog converter. Each channel owns a staging register, which a write loads, and a separate output register whose value drives that channel's code output. A 4-bit transparency mask lets chosen channels follow their staging register on every write. The other channels stay latched until an explicit update command copies the staged value across.

The same frame path also sets per-channel power-down flags and a shared power-down mode. It can turn an internal-reference enable on or off, and it offers two software reset strengths. The serial deframer sits upstream and presents one frame per valid cycle. The analog stage downstream consumes the code, flag, mode and enable outputs.

The frame input is a valid-only stream with no back-pressure. The block takes a frame on every clock edge where `frm_valid` is high, and the frame takes effect in that edge. The sender may therefore issue back-to-back frames without waiting. The outputs are registers and show the result of a frame one clock after its valid cycle.

Top module: `quad_dac_cmd_exec`

## Requirements
- R1: After reset every channel code is zero, every power-down flag is 0, the power-down mode is 00 and the reference enable is 0.
- R2: Command 000 loads `frm_data` into the staging register of each addressed channel. An addressed channel whose transparency bit is 1 also loads its output code from the new data, and the new code is visible one clock after the valid cycle. An addressed channel whose bit is 0 keeps its code.
- R3: Command 001 copies the staging register into the output code of each addressed channel, and the staging register keeps its value.
- R4: Command 010 loads `frm_data` into the addressed channel's staging register. In the same edge all four output codes load from their staging registers, and the addressed channel takes the new data.
- R5: Command 011 loads `frm_data` into both registers of each addressed channel, whatever the transparency mask holds.
- R6: Command 100 takes its mode from data bits 5:4 and its channel selection from data bits 3:0 (bit 0 is channel A, bit 3 is channel D). Each selected channel's power-down flag becomes 1 if the mode is nonzero and 0 if the mode is 00. A nonzero mode is copied to `pd_mode`. The output codes do not change.
- R7: Command 110 loads the transparency mask from data bits 3:0 (bit 0 is channel A), and the output codes do not change.
- R8: Command 111 sets the reference enable to data bit 0, and the output codes do not change.
- R9: Command 101 with data bit 0 = 0 clears every staging register and output code and leaves the mask, power-down state and reference enable alone. With data bit 0 = 1 it also clears the mask, the flags, the mode and the enable.
- R10: For commands 000 to 011, address values 0 to 3 select channels A to D and address 7 selects all four. Addresses 4, 5 and 6 make the frame a no-op. Channel i's code is at `dac_code[i*DW +: DW]`.
- R11: No register changes in a cycle where `frm_valid` is low, whatever the other frame inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| frm_valid | input | 1 | Frame present this cycle; always accepted |
| frm_cmd | input | 3 | Command code |
| frm_addr | input | 3 | Channel address |
| frm_data | input | DW | Data word |
| dac_code | output | 4*DW | Output codes, channel A in the low slice |
| pd_flag | output | 4 | Per-channel power-down flag, bit 0 = channel A |
| pd_mode | output | 2 | Shared power-down mode |
| ref_en | output | 1 | Internal reference enable |

## Verification
Most faults in this block sit in state that the ports never show directly: a wrong staging value, or a wrong mask bit. A corrupt staging value shows up only when a later update command, or command 010, copies it to a code output. The error then appears one clock after that frame. A bad mask bit shows on the first write of type 000 to that channel, where the code either moves when it should hold or holds when it should move. The bench therefore follows each hidden-state change with frames that force it out to the ports, and it compares every output against a reference model on every clock.

// File: rtl/dacq_pkg.sv
package dacq_pkg;
  localparam int NCH = 4;
  localparam logic [2:0] ADDR_ALL = 3'b111;

  typedef enum logic [2:0] {
    CMD_WR_IN   = 3'b000,
    CMD_UPD     = 3'b001,
    CMD_WR_UALL = 3'b010,
    CMD_WR_UPD  = 3'b011,
    CMD_PWR     = 3'b100,
    CMD_SRST    = 3'b101,
    CMD_MASK    = 3'b110,
    CMD_REF     = 3'b111
  } cmd_e;
endpackage

// File: rtl/dacq_decode.sv
module dacq_decode
  import dacq_pkg::*;
(
  input  logic           frm_valid,
  input  logic [2:0]     frm_cmd,
  input  logic [2:0]     frm_addr,
  input  logic [NCH-1:0] mask,
  output logic [NCH-1:0] ld_in,
  output logic [NCH-1:0] ld_dac,
  output logic           clr_codes,
  output logic           clr_ctrl,
  output logic           pd_we,
  output logic           mask_we,
  output logic           ref_we,
  input  logic           srst_full
);
  logic [NCH-1:0] sel;
  logic           addr_ok;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sel[i] = (frm_addr == 3'(i)) || (frm_addr == ADDR_ALL);
    end
    addr_ok = (frm_addr < 3'(NCH)) || (frm_addr == ADDR_ALL);
  end

  always_comb begin
    ld_in     = '0;
    ld_dac    = '0;
    clr_codes = 1'b0;
    clr_ctrl  = 1'b0;
    pd_we     = 1'b0;
    mask_we   = 1'b0;
    ref_we    = 1'b0;
    if (frm_valid) begin
      unique case (cmd_e'(frm_cmd))
        CMD_WR_IN: if (addr_ok) begin
          ld_in  = sel;
          ld_dac = sel & mask;
        end
        CMD_UPD: if (addr_ok) ld_dac = sel;
        CMD_WR_UALL: if (addr_ok) begin
          ld_in  = sel;
          ld_dac = '1;
        end
        CMD_WR_UPD: if (addr_ok) begin
          ld_in  = sel;
          ld_dac = sel;
        end
        CMD_PWR:  pd_we   = 1'b1;
        CMD_SRST: begin
          clr_codes = 1'b1;
          clr_ctrl  = srst_full;
        end
        CMD_MASK: mask_we = 1'b1;
        CMD_REF:  ref_we  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dacq_chan.sv
module dacq_chan #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_in,
  input  logic          ld_dac,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] code
);
  logic [DW-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      code    <= '0;
    end else if (clr) begin
      stage_q <= '0;
      code    <= '0;
    end else begin
      if (ld_in)  stage_q <= din;
      if (ld_dac) code    <= ld_in ? din : stage_q;
    end
  end
endmodule

// File: rtl/dacq_ctrl.sv
module dacq_ctrl
  import dacq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_ctrl,
  input  logic           pd_we,
  input  logic           mask_we,
  input  logic           ref_we,
  input  logic [5:0]     ctl_data,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] pd_flag,
  output logic [1:0]     pd_mode,
  output logic           ref_en
);
  logic going_down;
  assign going_down = |ctl_data[5:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask    <= '0;
      pd_flag <= '0;
      pd_mode <= 2'b00;
      ref_en  <= 1'b0;
    end else if (clr_ctrl) begin
      mask    <= '0;
      pd_flag <= '0;
      pd_mode <= 2'b00;
      ref_en  <= 1'b0;
    end else begin
      if (mask_we) mask <= ctl_data[NCH-1:0];
      if (ref_we)  ref_en <= ctl_data[0];
      if (pd_we) begin
        for (int i = 0; i < NCH; i++) begin
          if (ctl_data[i]) pd_flag[i] <= going_down;
        end
        if (going_down) pd_mode <= ctl_data[5:4];
      end
    end
  end
endmodule

// File: rtl/quad_dac_cmd_exec.sv
module quad_dac_cmd_exec
  import dacq_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [2:0]        frm_cmd,
  input  logic [2:0]        frm_addr,
  input  logic [DW-1:0]     frm_data,
  output logic [NCH*DW-1:0] dac_code,
  output logic [NCH-1:0]    pd_flag,
  output logic [1:0]        pd_mode,
  output logic              ref_en
);
  logic [NCH-1:0] ld_in, ld_dac, mask;
  logic           clr_codes, clr_ctrl, pd_we, mask_we, ref_we;

  dacq_decode u_dec (
    .frm_valid (frm_valid),
    .frm_cmd   (frm_cmd),
    .frm_addr  (frm_addr),
    .mask      (mask),
    .ld_in     (ld_in),
    .ld_dac    (ld_dac),
    .clr_codes (clr_codes),
    .clr_ctrl  (clr_ctrl),
    .pd_we     (pd_we),
    .mask_we   (mask_we),
    .ref_we    (ref_we),
    .srst_full (frm_data[0])
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dacq_chan #(.DW(DW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_codes),
      .ld_in  (ld_in[g]),
      .ld_dac (ld_dac[g]),
      .din    (frm_data),
      .code   (dac_code[g*DW +: DW])
    );
  end

  dacq_ctrl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_ctrl (clr_ctrl),
    .pd_we    (pd_we),
    .mask_we  (mask_we),
    .ref_we   (ref_we),
    .ctl_data (frm_data[5:0]),
    .mask     (mask),
    .pd_flag  (pd_flag),
    .pd_mode  (pd_mode),
    .ref_en   (ref_en)
  );
endmodule

// File: rtl/dacq_chk.sv
module dacq_chk
  import dacq_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_valid,
  input logic [2:0]        frm_cmd,
  input logic [2:0]        frm_addr,
  input logic [DW-1:0]     frm_data,
  input logic [NCH*DW-1:0] dac_code,
  input logic [NCH-1:0]    pd_flag,
  input logic [1:0]        pd_mode,
  input logic              ref_en
);
  a_r6_pd_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_cmd == 3'b100) |=> $stable(dac_code));

  a_r8_ref_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_cmd == 3'b111) |=> (ref_en == $past(frm_data[0])) && $stable(dac_code));

  a_r7_mask_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_cmd == 3'b110) |=> $stable(dac_code));

  a_r9_full_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_cmd == 3'b101 && frm_data[0]) |=>
      (dac_code == '0) && (pd_flag == '0) && (pd_mode == 2'b00) && !ref_en);

  a_r10_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_cmd[2] && frm_addr inside {3'd4, 3'd5, 3'd6}) |=> $stable(dac_code));

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> $stable(dac_code) && $stable(pd_flag) && $stable(pd_mode) && $stable(ref_en));
endmodule

bind quad_dac_cmd_exec dacq_chk #(.DW(DW)) u_chk (.*);

// File: tb/quad_dac_cmd_exec_tb.sv
module quad_dac_cmd_exec_tb;
  localparam int DW  = 16;
  localparam int NCH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frm_valid = 1'b0;
  logic [2:0]        frm_cmd = '0;
  logic [2:0]        frm_addr = '0;
  logic [DW-1:0]     frm_data = '0;
  logic [NCH*DW-1:0] dac_code;
  logic [NCH-1:0]    pd_flag;
  logic [1:0]        pd_mode;
  logic              ref_en;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc   = 0;
  bit    done  = 1'b0;
  string tag   = "R1";

  // reference model state
  logic [DW-1:0]  m_in  [NCH];
  logic [DW-1:0]  m_dac [NCH];
  logic [NCH-1:0] m_mask, m_pd;
  logic [1:0]     m_mode;
  logic           m_ref;

  always #4 clk = ~clk;

  quad_dac_cmd_exec #(.DW(DW)) u_dut (.*);

  function automatic bit hit(input logic [2:0] a, input int ch);
    return (a == 3'(ch)) || (a == 3'd7);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_dac[i] = '0; end
      m_mask = '0; m_pd = '0; m_mode = '0; m_ref = 1'b0;
    end else if (frm_valid) begin
      bit ok;
      ok = (frm_addr <= 3'd3) || (frm_addr == 3'd7);
      case (frm_cmd)
        3'd0: if (ok) for (int i = 0; i < NCH; i++) if (hit(frm_addr, i)) begin
                m_in[i] = frm_data;
                if (m_mask[i]) m_dac[i] = frm_data;
              end
        3'd1: if (ok) for (int i = 0; i < NCH; i++) if (hit(frm_addr, i)) m_dac[i] = m_in[i];
        3'd2: if (ok) begin
                for (int i = 0; i < NCH; i++) if (hit(frm_addr, i)) m_in[i] = frm_data;
                for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
              end
        3'd3: if (ok) for (int i = 0; i < NCH; i++) if (hit(frm_addr, i)) begin
                m_in[i] = frm_data; m_dac[i] = frm_data;
              end
        3'd4: begin
                for (int i = 0; i < NCH; i++) if (frm_data[i]) m_pd[i] = (frm_data[5:4] != 2'b00);
                if (frm_data[5:4] != 2'b00) m_mode = frm_data[5:4];
              end
        3'd5: begin
                for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_dac[i] = '0; end
                if (frm_data[0]) begin m_mask = '0; m_pd = '0; m_mode = '0; m_ref = 1'b0; end
              end
        3'd6: m_mask = frm_data[3:0];
        default: m_ref = frm_data[0];
      endcase
    end
  end

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // compare everything on every falling edge once out of reset
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      for (int i = 0; i < NCH; i++) chk($sformatf("code ch%0d", i), dac_code[i*DW +: DW], m_dac[i]);
      chk("pd_flag", DW'(pd_flag), DW'(m_pd));
      chk("pd_mode", DW'(pd_mode), DW'(m_mode));
      chk("ref_en",  DW'(ref_en),  DW'(m_ref));
    end
  end

  task automatic send(input logic [2:0] c, input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    frm_valid = 1'b1; frm_cmd = c; frm_addr = a; frm_data = d;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";   // reset state, literal expectations
    chk("reset codes", DW'(dac_code == '0), DW'(1));
    chk("reset ref/pd", DW'({ref_en, pd_mode, pd_flag}), DW'(0));

    tag = "R2";   send(3'd0, 3'd0, 16'h1234); send(3'd0, 3'd7, 16'h5555);
    chk("R2 latched A", dac_code[0 +: DW], 16'h0000);
    tag = "R3";   send(3'd1, 3'd1, 16'h0); send(3'd1, 3'd7, 16'h0);
    chk("R3 all updated D", dac_code[3*DW +: DW], 16'h5555);
    tag = "R7";   send(3'd6, 3'd0, 16'h0005);
    tag = "R2";   send(3'd0, 3'd0, 16'hAAAA); send(3'd0, 3'd1, 16'hBBBB);
    chk("R2 transparent A", dac_code[0 +: DW], 16'hAAAA);
    chk("R2 latched B", dac_code[DW +: DW], 16'h5555);
    tag = "R4";   send(3'd2, 3'd3, 16'h0F0F);
    chk("R4 B from staging", dac_code[DW +: DW], 16'hBBBB);
    tag = "R5";   send(3'd3, 3'd2, 16'h7777);
    tag = "R6";   send(3'd4, 3'd0, 16'h0026); send(3'd4, 3'd0, 16'h0002);
    send(3'd4, 3'd0, 16'h001F);
    chk("R6 mode", DW'(pd_mode), DW'(2'b01));
    tag = "R8";   send(3'd7, 3'd0, 16'h1); send(3'd7, 3'd0, 16'hFFFE); send(3'd7, 3'd0, 16'h1);
    tag = "R10";  send(3'd0, 3'd5, 16'h9999); send(3'd3, 3'd4, 16'h9999); send(3'd1, 3'd6, 16'h0);
    send(3'd2, 3'd4, 16'h9999);
    tag = "R11";
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); frm_cmd = 3'(k); frm_addr = 3'd7; frm_data = 16'hFFFF;
    end
    tag = "R9";   send(3'd5, 3'd0, 16'h0); send(3'd1, 3'd7, 16'h0);
    chk("R9 ref kept", DW'(ref_en), DW'(1));
    send(3'd5, 3'd0, 16'h1);
    send(3'd0, 3'd0, 16'h4321);
    chk("R9 mask cleared", dac_code[0 +: DW], 16'h0000);

    tag = "random R2..R11";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      frm_valid = ($urandom_range(0, 3) != 0);
      frm_cmd   = 3'($urandom_range(0, 7));
      if (frm_cmd == 3'd5 && $urandom_range(0, 3) != 0) frm_cmd = 3'd0;
      frm_addr  = 3'($urandom_range(0, 7));
      frm_data  = DW'($urandom);
    end
    @(negedge clk); frm_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    done = 1'b1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule